// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block turns a raw, asynchronous, active-low reset pin into a clean, synchronous, active-high reset level for a processor core. The pin may be noisy, so it first passes through a flop synchronizer. A pulse-width filter then accepts a reset only when the pin has stayed low for long enough. Short glitches leave the core running.

An accepted reset is held for a minimum number of clocks. If the pin stays low past that minimum, the reset is held until the pin goes high again. When the reset ends, a one-clock pulse tells the core to load its fixed start address. The start address is also driven on a port.

The controller is a Moore machine with five states:
- `ST_RUN`: the core is running.
- `ST_QUAL`: the pin is low and the filter is counting.
- `ST_HOLD`: the internal reset is asserted and the minimum hold is counting.
- `ST_WAIT`: the minimum hold is over and the pin is still low.
- `ST_DONE`: the one-clock release pulse.

The transitions are:
- run→qual on a low sample.
- qual→run on a high sample.
- qual→hold on the fifth consecutive low sample.
- hold→done when the count reaches the minimum and the pin is high.
- hold→wait when the count reaches the minimum and the pin is low.
- wait→done when the pin rises.
- done→run always.

Top module: `rst_filter_seq`

## Requirements
- R1: A pin low pulse that covers at most 4 rising clock edges never asserts `core_rst`.
- R2: A high sample of the synchronized pin during filtering restarts the count. Two low pulses of 3 edges each, separated by one high edge, produce no reset.
- R3: When the pin is driven low just after rising edge m and stays low, `core_rst` is first high after edge m+7. That is 2 synchronizer edges plus a fifth consecutive low sample in the filter.
- R4: Once asserted, `core_rst` stays high for at least 18 clocks.
- R5: For a pin pulse covering L edges, `core_rst` stays high for exactly max(18, L-4) clocks. It follows the pin release when L exceeds 22.
- R6: `rst_done` is high for exactly one clock, in the first clock after `core_rst` falls, and at no other time.
- R7: `start_addr` always equals 0x000C.
- R8: From power-up with the pin high, `core_rst` and `rst_done` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| ext_rst_n | input | 1 | Raw asynchronous reset pin, active low |
| core_rst | output | 1 | Clean internal reset, active high |
| rst_done | output | 1 | One-clock pulse at the end of reset |
| start_addr | output | 16 | Program start address loaded after reset |

## Verification
A wrong filter count shows up at the ports within a few clocks of the pin falling. Either the reset rises at the wrong edge, or a short pulse produces a reset it should not. A wrong hold count or a missed pin-release transition shows as a reset episode of the wrong width, visible at its falling edge. A stuck or repeated `ST_DONE` shows as a missing or extra `rst_done` pulse in the clock right after the fall.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_QUAL = 3'd1,
        ST_HOLD = 3'd2,
        ST_WAIT = 3'd3,
        ST_DONE = 3'd4
    } seq_state_t;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_n_sync
);
    // Power-up value is "pin released" so nothing starts in reset.
    logic [STAGES-1:0] chain = '1;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain[0] <= pin_n;
        end else begin : g_multi
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], pin_n};
        end
    endgenerate

    assign pin_n_sync = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rstseq_pkg::*;
#(
    parameter int ACCEPT_LOW = 5,
    parameter int MIN_HOLD   = 18
) (
    input  logic clk,
    input  logic pin_n_sync,
    output logic core_rst,
    output logic rst_done
);
    localparam int CNT_MAX = (ACCEPT_LOW > MIN_HOLD) ? ACCEPT_LOW : MIN_HOLD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACCEPT_LOW - 1);
    localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(MIN_HOLD);

    seq_state_t       state_q = ST_RUN;
    seq_state_t       state_d;
    logic [CNT_W-1:0] cnt_q = '0;
    logic [CNT_W-1:0] cnt_d;

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (!pin_n_sync) begin
                    state_d = ST_QUAL;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_QUAL: begin
                if (pin_n_sync) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == ACC_LAST) begin
                    state_d = ST_HOLD;
                    cnt_d   = CNT_W'(1);
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == HOLD_END) begin
                    state_d = pin_n_sync ? ST_DONE : ST_WAIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WAIT: begin
                if (pin_n_sync) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        core_rst = 1'b0;
        rst_done = 1'b0;
        unique case (state_q)
            ST_HOLD, ST_WAIT: core_rst = 1'b1;
            ST_DONE:          rst_done = 1'b1;
            default: ;
        endcase
    end

    // ---------------- checks ----------------
    logic             chk_live = 1'b0;
    logic [CNT_W-1:0] low_run  = '0;
    logic [CNT_W-1:0] rst_len  = '0;

    always_ff @(posedge clk) begin
        chk_live <= 1'b1;
        if (pin_n_sync)                              low_run <= '0;
        else if (low_run != CNT_W'(ACCEPT_LOW))      low_run <= low_run + 1'b1;
        if (!core_rst)                               rst_len <= '0;
        else if (rst_len != HOLD_END)                rst_len <= rst_len + 1'b1;
    end

    a_r3_latch_after_filter: assert property (@(posedge clk) disable iff (!chk_live)
        $rose(core_rst) |-> (low_run == CNT_W'(ACCEPT_LOW)));

    a_r4_min_hold: assert property (@(posedge clk) disable iff (!chk_live)
        $fell(core_rst) |-> (rst_len == HOLD_END));

    a_r5_pin_low_keeps_reset: assert property (@(posedge clk) disable iff (!chk_live)
        (core_rst && !pin_n_sync) |=> core_rst);

    a_r6_done_after_fall: assert property (@(posedge clk) disable iff (!chk_live)
        $fell(core_rst) |-> rst_done);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!chk_live)
        rst_done |=> !rst_done);
endmodule

// File: rtl/rst_filter_seq.sv
module rst_filter_seq #(
    parameter int          SYNC_STAGES = 2,
    parameter int          ACCEPT_LOW  = 5,
    parameter int          MIN_HOLD    = 18,
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] START_ADDR  = 16'h000C
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    output logic              core_rst,
    output logic              rst_done,
    output logic [ADDR_W-1:0] start_addr
);
    logic pin_n_sync;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .pin_n      (ext_rst_n),
        .pin_n_sync (pin_n_sync)
    );

    rst_seq_fsm #(.ACCEPT_LOW(ACCEPT_LOW), .MIN_HOLD(MIN_HOLD)) u_fsm (
        .clk        (clk),
        .pin_n_sync (pin_n_sync),
        .core_rst   (core_rst),
        .rst_done   (rst_done)
    );

    assign start_addr = ADDR_W'(START_ADDR);
endmodule

// File: tb/rst_filter_seq_test.sv
module rst_filter_seq_test;
    typedef struct {
        int start_cyc;
        int width;
    } episode_t;

    logic        clk = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        core_rst;
    logic        rst_done;
    logic [15:0] start_addr;

    int       cyc = 0;
    int       n_cmp = 0;
    int       n_bad = 0;
    bit       finished = 0;
    episode_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_filter_seq uut (
        .clk        (clk),
        .ext_rst_n  (ext_rst_n),
        .core_rst   (core_rst),
        .rst_done   (rst_done),
        .start_addr (start_addr)
    );

    task automatic check(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Driver: pin low across L rising edges; pushes expected episode (R1, R3, R5)
    task automatic pulse(input int len);
        @(negedge clk);
        if (len >= 5) begin
            episode_t e;
            e.start_cyc = cyc + 7;
            e.width     = (len - 4 > 18) ? len - 4 : 18;
            exp_q.push_back(e);
        end
        ext_rst_n = 1'b0;
        repeat (len) @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor
    logic prev_rst  = 1'b0;
    logic prev_done = 1'b0;
    int   rise_cyc  = 0;
    int   cur_w     = 0;
    always @(negedge clk) begin
        check("R7 start address", int'(start_addr), 12);
        if (core_rst && !prev_rst) begin
            rise_cyc = cyc;
            cur_w    = 0;
            if (exp_q.size() == 0) check("R1/R2 unexpected reset", 1, 0);
            else check("R3 assert edge", cyc, exp_q[0].start_cyc);
        end
        if (core_rst) cur_w++;
        if (!core_rst && prev_rst) begin
            check("R6 done after fall", int'(rst_done), 1);
            if (exp_q.size() != 0) begin
                check("R4/R5 reset width", cur_w, exp_q[0].width);
                void'(exp_q.pop_front());
            end
        end else if (rst_done) begin
            check("R6 done only after fall", int'(rst_done), 0);
        end
        if (prev_done) check("R6 done one cycle", int'(rst_done), 0);
        prev_rst  = core_rst;
        prev_done = rst_done;
    end

    initial begin
        #1;
        check("R8 power-up reset low", int'(core_rst), 0);
        check("R8 power-up done low", int'(rst_done), 0);
        idle(5);
        check("R8 idle reset low", int'(core_rst), 0);
        pulse(1);  idle(30);   // R1
        pulse(4);  idle(30);   // R1 boundary
        pulse(3); idle(1); pulse(3); idle(30);   // R2 restart
        pulse(5);  idle(40);   // R3, R4 boundary acceptance
        pulse(22); idle(40);   // R4/R5 boundary
        pulse(23); idle(40);   // R5 one beyond
        pulse(40); idle(40);   // R5 stretched
        pulse(8);  idle(40);   // R4 minimum
        check("R1-R5 all episodes seen", exp_q.size(), 0);
        check("R8 final reset low", int'(core_rst), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule